// File: doc/BRIEF.md
# Shortened Write-Strobe Generator for a Phase-2 Memory Bus

This block drives the active-low write enable and output enable of an SRAM or flash device attached to a 6502-style system bus. It watches the bus phase-2 clock and the read/write line through a fast local clock. Reads get an output enable that follows the whole phase-2 high time. Writes get a write enable cut from a shorter pulse. That pulse starts when phase-2 rises and lasts a programmed number of fast-clock cycles. The memory therefore latches its data before the processor starts to move the data lines, which it may do shortly before phase-2 falls.

Phase-2 and read/write are asynchronous to the fast clock, so both pass through a two-flop synchronizer. A rising-edge detector on the synchronized phase-2 starts the pulse. The pulse ends early if phase-2 drops first. Once a pulse has run, it does not start again until phase-2 has gone low and risen again. At a 1.79 MHz bus, phase-2 is high for about 280 ns. The default of 21 cycles at 125 MHz gives a strobe of about 168 ns.

Top module: `strobe_shaper`

## Requirements
- R1: In a read cycle (bus_rw = 1), mem_oe_n goes low two clock edges after the first edge that samples bus_phi2 high. It stays low for exactly as many cycles as bus_phi2 was sampled high, and it forms a single low run.
- R2: In a write cycle (bus_rw = 0) whose phase-2 high time H is longer than PULSE_CYC cycles, mem_we_n goes low three edges after the first edge that samples bus_phi2 high. It stays low for exactly PULSE_CYC cycles.
- R3: In a write cycle where H - 1 < PULSE_CYC, the write pulse is cut short. mem_we_n is low for H - 1 cycles and is high again two edges after bus_phi2 is first sampled low.
- R4: During one phase-2 high period, mem_we_n forms at most one low run, however long the period lasts. A pulse that has ended does not restart until phase-2 has been low.
- R5: mem_we_n and mem_oe_n are never low together. mem_we_n never goes low in a read cycle, and mem_oe_n never goes low in a write cycle. Both outputs are high while phase-2 is low.
- R6: While rst_n is low (synchronous, active low), both outputs are high at every clock edge, whatever the bus inputs do.
- R7: When H >= PULSE_CYC + 6, mem_we_n is back high for at least three cycles (24 ns at 125 MHz) before bus_phi2 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_phi2 | input | 1 | Bus phase-2 clock, asynchronous |
| bus_rw | input | 1 | Bus read/write line: 1 = read, 0 = write; asynchronous |
| mem_we_n | output | 1 | Memory write enable, active low, registered |
| mem_oe_n | output | 1 | Memory output enable, active low, registered |

## Verification
The bench aims at several corner cases.

- **Phase-2 high for a single cycle, or shorter than the pulse.** A design that let its counter run after phase-2 fell would stretch the write strobe into the low phase and past the data-valid window.
- **Phase-2 held high for far longer than the pulse.** A design that retriggered would show a second write strobe in the same bus cycle.
- **Typical 1.79 MHz cycles with random read/write.** The bench measures the margin between the end of the write strobe and the phase-2 fall. It also measures the output-enable length. An off-by-one in the counter or the synchronizer latency shows up there as a wrong strobe length.
- **Phase-2 toggling while reset is held.** This exposes outputs that are not forced high during reset.

// File: rtl/wss_pkg.sv
// Package: shared types for the shortened write-strobe generator.
// Assumes: nothing beyond plain synthesizable types.
package wss_pkg;

    // Pulse generator state: waiting for a rise, counting, or finished for this phase.
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_RUN   = 2'd1,
        PS_SPENT = 2'd2
    } pulse_state_t;

    // Pair of synchronized bus control signals.
    typedef struct packed {
        logic phi2;
        logic rw;
    } bus_ctl_t;

endpackage

// File: rtl/wss_sync.sv
// Module: wss_sync
// Multi-stage synchronizer for WIDTH independent asynchronous bits.
// Assumes: each bit is a level that stays stable for several clk cycles;
// no relationship between bits is preserved through the stages.
module wss_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous inputs into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Shift the previous stage forward to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/wss_pulse.sv
// Module: wss_pulse
// Detects the rising edge of the synchronized phase-2 clock and produces a
// pulse PULSE_CYC cycles long. The pulse ends early when phase-2 drops. It
// cannot retrigger until phase-2 has been seen low.
// Assumes: phi_s is already synchronous to clk; PULSE_CYC >= 1.
module wss_pulse
    import wss_pkg::*;
#(
    parameter int PULSE_CYC = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_s,
    output logic pulse
);

    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_CYC);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    pulse_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          phi_q;
    logic          rise;

    // Delay phi_s by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) phi_q <= 1'b0;
        else        phi_q <= phi_s;
    end

    assign rise = phi_s & ~phi_q;

    // Next-state and counter logic of the pulse sequencer.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                if (rise) begin
                    state_d = PS_RUN;
                    cnt_d   = CNT_ONE;
                end
            end
            PS_RUN: begin
                if (!phi_s) begin
                    state_d = PS_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = PS_SPENT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            PS_SPENT: begin
                if (!phi_s) state_d = PS_IDLE;
            end
            default: begin
                state_d = PS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Register the sequencer state and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign pulse = (state_q == PS_RUN);

endmodule

// File: rtl/wss_outreg.sv
// Module: wss_outreg
// Registers the active-low memory strobes. Write follows the short pulse
// gated by phase-2 and a write; read follows the full phase-2 gated by a read.
// Assumes: all inputs are synchronous to clk.
module wss_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_s,
    input  logic rw_s,
    input  logic pulse,
    output logic we_n,
    output logic oe_n
);

    // Drive both strobes from registers; both idle high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n <= 1'b1;
            oe_n <= 1'b1;
        end else begin
            we_n <= ~(pulse & phi_s & ~rw_s);
            oe_n <= ~(phi_s & rw_s);
        end
    end

endmodule

// File: rtl/strobe_shaper.sv
// Module: strobe_shaper (top)
// Generates the memory write enable from a shortened copy of the phase-2
// high pulse, and the output enable from the full phase-2 high pulse.
// Assumes: clk is much faster than phase-2; bus_rw is stable around the
// phase-2 rising edge; PULSE_CYC cycles fit inside the phase-2 high time
// with margin.
module strobe_shaper
    import wss_pkg::*;
#(
    parameter int PULSE_CYC   = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_phi2,
    input  logic bus_rw,
    output logic mem_we_n,
    output logic mem_oe_n
);

    localparam int CTL_W = $bits(bus_ctl_t);

    bus_ctl_t ctl_async;
    bus_ctl_t ctl_sync;
    logic     phi2_sync;
    logic     rw_sync;
    logic     short_pulse;

    assign ctl_async.phi2 = bus_phi2;
    assign ctl_async.rw   = bus_rw;

    wss_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_async),
        .sync_out (ctl_sync)
    );

    assign phi2_sync = ctl_sync.phi2;
    assign rw_sync   = ctl_sync.rw;

    wss_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .phi_s (phi2_sync),
        .pulse (short_pulse)
    );

    wss_outreg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .phi_s (phi2_sync),
        .rw_s  (rw_sync),
        .pulse (short_pulse),
        .we_n  (mem_we_n),
        .oe_n  (mem_oe_n)
    );

endmodule

// File: rtl/strobe_shaper_chk.sv
// Module: strobe_shaper_chk
// Assertion checker bound to strobe_shaper. Watches the synchronized bus
// controls and the registered strobes.
// Assumes: used only through the bind statement below.
module strobe_shaper_chk #(
    parameter int PULSE_CYC = 21
) (
    input logic clk,
    input logic rst_n,
    input logic phi_s,
    input logic rw_s,
    input logic we_n,
    input logic oe_n
);

    int unsigned we_run;

    // Count consecutive cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)     we_run <= 0;
        else if (!we_n) we_run <= we_run + 1;
        else            we_run <= 0;
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    assert_we_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_run <= PULSE_CYC);

    assert_reset_idle_R6: assert property (@(posedge clk)
        !rst_n |=> (we_n && oe_n));

    assert_oe_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(phi_s) && $past(rw_s));

    assert_we_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(phi_s) && !$past(rw_s));

endmodule

bind strobe_shaper strobe_shaper_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phi_s (phi2_sync),
    .rw_s  (rw_sync),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n)
);

// File: tb/test_strobe_shaper.sv
`timescale 1ns/1ps
module test_strobe_shaper;

    localparam int PULSE = 21;

    typedef struct {
        bit rw;
        int h;
        int exp_we;
        int exp_oe;
        int exp_we_runs;
        int exp_oe_runs;
        bit chk_gap;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_phi2 = 1'b0;
    logic bus_rw = 1'b1;
    logic mem_we_n, mem_oe_n;

    int checks = 0;
    int fails = 0;
    bit frame_done = 1'b0;
    bit finished = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    strobe_shaper #(.PULSE_CYC(PULSE)) i_strobe_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_phi2 (bus_phi2),
        .bus_rw   (bus_rw),
        .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one bus cycle with L low cycles and H high cycles of phase-2.
    task automatic bus_cycle(input int l, input int h, input bit rw);
        item_t it;
        it.rw = rw;
        it.h = h;
        it.exp_oe = rw ? h : 0;
        it.exp_oe_runs = rw ? 1 : 0;
        it.exp_we = rw ? 0 : ((h - 1 < PULSE) ? h - 1 : PULSE);
        it.exp_we_runs = (it.exp_we > 0) ? 1 : 0;
        it.chk_gap = !rw && (h >= PULSE + 6);
        sb_q.push_back(it);
        @(negedge clk);
        bus_rw = rw;
        for (int i = 0; i < l; i++) @(negedge clk);
        bus_phi2 = 1'b1;
        for (int i = 0; i < h; i++) @(negedge clk);
        bus_phi2 = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    // Monitor: measures strobes per frame, pops expected items and compares.
    initial begin : monitor
        int we_cnt, oe_cnt, we_runs, oe_runs, overlap, gap, gap_at_fall, late;
        bit pwe, poe, pphi;
        item_t it;
        we_cnt = 0; oe_cnt = 0; we_runs = 0; oe_runs = 0; overlap = 0;
        gap = 0; gap_at_fall = 0; late = 0; pwe = 1; poe = 1; pphi = 0;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (!mem_we_n) we_cnt++;
                if (!mem_oe_n) oe_cnt++;
                if (pwe && !mem_we_n) we_runs++;
                if (poe && !mem_oe_n) oe_runs++;
                if (!mem_we_n && !mem_oe_n) overlap++;
                if (bus_phi2) gap = (!mem_we_n) ? 0 : gap + 1;
                if (!bus_phi2 && !mem_we_n) late++;
                if (pphi && !bus_phi2) gap_at_fall = gap;
                pwe = mem_we_n; poe = mem_oe_n; pphi = bus_phi2;
                if (frame_done && sb_q.size() > 0) begin
                    it = sb_q.pop_front();
                    if (it.rw) check(oe_cnt == it.exp_oe, "R1 oe low length", oe_cnt, it.exp_oe);
                    else if (it.h - 1 < PULSE) check(we_cnt == it.exp_we, "R3 cut write length", we_cnt, it.exp_we);
                    else check(we_cnt == it.exp_we, "R2 write pulse length", we_cnt, it.exp_we);
                    check(we_runs == it.exp_we_runs, "R4 write run count", we_runs, it.exp_we_runs);
                    check(oe_runs == it.exp_oe_runs, "R1 oe run count", oe_runs, it.exp_oe_runs);
                    check(overlap == 0, "R5 overlap", overlap, 0);
                    if (it.rw) check(we_cnt == 0, "R5 we during read", we_cnt, 0);
                    else check(oe_cnt == 0, "R5 oe during write", oe_cnt, 0);
                    if (it.chk_gap) begin
                        check(gap_at_fall >= 3, "R7 margin before fall", gap_at_fall, 3);
                        check(late == 0, "R7 we after fall", late, 0);
                    end
                    we_cnt = 0; oe_cnt = 0; we_runs = 0; oe_runs = 0;
                    overlap = 0; gap = 0; gap_at_fall = 0; late = 0;
                end
            end
        end
    end

    // Stimulus: reset, directed corner cases, then random 1.79 MHz traffic.
    initial begin : stim
        rst_n = 1'b0;
        bus_phi2 = 1'b1;
        bus_rw = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mem_we_n && mem_oe_n, "R6 outputs idle in reset", {mem_we_n, mem_oe_n}, 3);
            bus_phi2 = ~bus_phi2;
            bus_rw = (i % 3) != 0;
        end
        bus_phi2 = 1'b0;
        bus_rw = 1'b1;
        @(negedge clk);
        check(mem_we_n && mem_oe_n, "R6 outputs idle in reset", {mem_we_n, mem_oe_n}, 3);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(mem_we_n && mem_oe_n, "R6 outputs idle after reset", {mem_we_n, mem_oe_n}, 3);

        bus_cycle(35, 35, 1'b1);   // R1 typical read
        bus_cycle(35, 35, 1'b0);   // R2/R7 typical write
        bus_cycle(10, 1, 1'b0);    // R3 single-cycle high
        bus_cycle(10, 2, 1'b1);    // R1 short read
        bus_cycle(10, 10, 1'b0);   // R3 cut short
        bus_cycle(10, PULSE, 1'b0);     // R3 boundary
        bus_cycle(10, PULSE + 1, 1'b0); // R2 boundary
        bus_cycle(10, 200, 1'b0);  // R4 long high, no retrigger
        bus_cycle(10, 200, 1'b1);  // R1 long read
        for (int n = 0; n < 120; n++) begin
            bus_cycle(33 + $urandom_range(0, 4), 33 + $urandom_range(0, 4), 1'($urandom_range(0, 1)));
        end
        for (int n = 0; n < 40; n++) begin
            bus_cycle($urandom_range(3, 40), $urandom_range(1, 60), 1'($urandom_range(0, 1)));
        end
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin : watchdog
        #(8 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule